// File: doc/BRIEF.md
# Low-Side Channel Enable and Overload Latch Logic

This block decides, for each of eight low-side power channels, whether the output transistor gate is driven. It merges three sources. The first is an 8-bit command word, taken from the serial interface's output latch. The second is a pair of active-low direct pins that give the first two channels a fast path for pulse-width control. The third is a set of per-channel overload latches that shut a channel down after a fault.

The overload latches depend on the channel's class. Channels 1 to 6 are meant for loads without inrush current. On these, an overcurrent flag must stay high for a programmable number of system clocks before the latch sets. Channels 7 and 8 regulate their current on their own, so only an overtemperature flag trips them, and it does so at once. A latch stays set until the channel is commanded off or the chip enters internal reset. After that, a new command can turn the channel on again.

The block also forms the chip's internal reset. This reset is asserted when the external reset pin is low or when the undervoltage flag is high. While it is asserted, every drive enable is off and every overload latch is cleared.

Top module: `lsd_chan_ctrl`

## Requirements
- R1: Channel 1 (`drive_o[0]`) is on when `cmd_i[0]` is 1 or `direct_ni[0]` is 0, and channel 2 (`drive_o[1]`) is on when `cmd_i[1]` is 1 or `direct_ni[1]` is 0. A direct pin held high, as its pull-up leaves it, adds nothing. Only latch and reset gating, as in R10, can override this.
- R2: Channels 3 to 8 (`drive_o[7:2]`) follow `cmd_i[7:2]` bit for bit: 1 is on, 0 is off. The direct pins have no effect on them.
- R3: `int_rst_o` is 1 exactly when `ext_rst_ni` is 0 or `uv_i` is 1. It forces all of `drive_o` to 0 in the same cycle, with no clock edge in between.
- R4: A clock edge that sees `int_rst_o` high clears every overload latch. Once reset is released, channels follow their command again.
- R5: On channels 1 to 6, the overload latch sets at the clock edge where the channel's overcurrent flag (`oc_i[k]` for channel k+1) has been sampled high, with the channel commanded on, on `OC_DLY_CYC` consecutive edges. From then on `ovl_o` shows the latch and the drive is off.
- R6: If the overcurrent flag drops for one edge, the delay count restarts. A full `OC_DLY_CYC` consecutive high samples are needed again.
- R7: On channels 7 and 8, the latch sets at the first clock edge that samples the channel's overtemperature flag (`ot_i[0]` for channel 7, `ot_i[1]` for channel 8) high while the channel is commanded on.
- R8: A set latch holds while the channel stays commanded on, even after its fault flag drops. It clears at the first edge that sees the channel commanded off.
- R9: Fault flags on a channel that is commanded off never set that channel's latch.
- R10: `drive_o[k]` equals the commanded state AND NOT `ovl_o[k]` AND NOT `int_rst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low logic reset |
| cmd_i | input | 8 | Latched serial command, bit k is channel k+1 |
| direct_ni | input | 2 | Active-low direct control for channels 1 and 2 |
| oc_i | input | 6 | Overcurrent flags, channels 1 to 6 |
| ot_i | input | 2 | Overtemperature flags, channels 7 and 8 |
| ext_rst_ni | input | 1 | External chip reset pin, active low |
| uv_i | input | 1 | Supply undervoltage flag |
| drive_o | output | 8 | Gate enables, bit k is channel k+1 |
| ovl_o | output | 8 | Overload latch states |
| int_rst_o | output | 1 | Internal chip reset |

## Verification
An overload latch stuck high shows at once as a channel that ignores a 1 in its command, and it stays visible on `ovl_o`. A latch that never clears shows up one edge after the command goes off and then on again. A delay counter that is off by one moves the trip edge, so the bench samples `ovl_o` both one edge before and exactly at the expected trip edge. A counter that fails to restart shows up as an early trip after a one-cycle dropout. Errors in the reset or decode logic are combinational, so they appear on `drive_o` within the same cycle as the input change.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  localparam int unsigned NUM_CH     = 8;
  localparam int unsigned NUM_DIRECT = 2;
  localparam int unsigned NUM_OC     = 6;
  localparam int unsigned NUM_OT     = NUM_CH - NUM_OC;

  typedef enum logic {
    CLS_OVERCURRENT = 1'b0,
    CLS_OVERTEMP    = 1'b1
  } ovl_class_e;
endpackage

// File: rtl/lsd_rst_comb.sv
module lsd_rst_comb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_rst_ni,
  input  logic uv_i,
  output logic int_rst_o
);
  assign int_rst_o = ~ext_rst_ni | uv_i;

  p_uv_forces_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uv_i || !ext_rst_ni) |-> int_rst_o);
  p_idle_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!uv_i && ext_rst_ni) |-> !int_rst_o);
endmodule

// File: rtl/lsd_cmd_decode.sv
module lsd_cmd_decode #(
  parameter int unsigned NUM_CH     = lsd_pkg::NUM_CH,
  parameter int unsigned NUM_DIRECT = lsd_pkg::NUM_DIRECT
) (
  input  logic [NUM_CH-1:0]     cmd_i,
  input  logic [NUM_DIRECT-1:0] direct_ni,
  output logic [NUM_CH-1:0]     want_o
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    if (ch < NUM_DIRECT) begin : g_direct
      // direct pin low wins over a 0 command bit
      assign want_o[ch] = cmd_i[ch] | ~direct_ni[ch];
    end else begin : g_serial
      assign want_o[ch] = cmd_i[ch];
    end
  end
endmodule

// File: rtl/lsd_ovl_ch.sv
module lsd_ovl_ch #(
  parameter lsd_pkg::ovl_class_e CLS        = lsd_pkg::CLS_OVERCURRENT,
  parameter int unsigned         OC_DLY_CYC = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic want_i,
  input  logic fault_i,
  output logic ovl_o
);
  localparam int unsigned CW = (OC_DLY_CYC > 1) ? $clog2(OC_DLY_CYC) : 1;

  logic ovl_q;
  assign ovl_o = ovl_q;

  if (CLS == lsd_pkg::CLS_OVERCURRENT) begin : g_oc
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
        ovl_q <= 1'b0;
      end else if (clr_i || !want_i) begin
        cnt_q <= '0;
        ovl_q <= 1'b0;
      end else if (ovl_q) begin
        cnt_q <= '0;
      end else if (fault_i) begin
        if (cnt_q == CW'(OC_DLY_CYC - 1)) begin
          cnt_q <= '0;
          ovl_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end

    p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q < CW'(OC_DLY_CYC) || OC_DLY_CYC == 1);
    p_trip_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ovl_q) |-> $past(fault_i && want_i && !clr_i));
  end else begin : g_ot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ovl_q <= 1'b0;
      end else if (clr_i || !want_i) begin
        ovl_q <= 1'b0;
      end else if (fault_i) begin
        ovl_q <= 1'b1;
      end
    end

    p_trip_now_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fault_i && want_i && !clr_i) |=> ovl_q);
  end

  p_clear_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !want_i |=> !ovl_q);
  p_clear_rst_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !ovl_q);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovl_q && want_i && !clr_i) |=> ovl_q);
endmodule

// File: rtl/lsd_chan_ctrl.sv
module lsd_chan_ctrl #(
  parameter int unsigned OC_DLY_CYC = 500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] cmd_i,
  input  logic [1:0] direct_ni,
  input  logic [5:0] oc_i,
  input  logic [1:0] ot_i,
  input  logic       ext_rst_ni,
  input  logic       uv_i,
  output logic [7:0] drive_o,
  output logic [7:0] ovl_o,
  output logic       int_rst_o
);
  import lsd_pkg::*;

  logic [NUM_CH-1:0] want;
  logic [NUM_CH-1:0] ovl;
  logic              int_rst;

  lsd_rst_comb u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_rst_ni (ext_rst_ni),
    .uv_i       (uv_i),
    .int_rst_o  (int_rst)
  );

  lsd_cmd_decode #(
    .NUM_CH     (NUM_CH),
    .NUM_DIRECT (NUM_DIRECT)
  ) u_dec (
    .cmd_i     (cmd_i),
    .direct_ni (direct_ni),
    .want_o    (want)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    if (ch < NUM_OC) begin : g_oc
      lsd_ovl_ch #(
        .CLS        (CLS_OVERCURRENT),
        .OC_DLY_CYC (OC_DLY_CYC)
      ) u_ovl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (int_rst),
        .want_i  (want[ch]),
        .fault_i (oc_i[ch]),
        .ovl_o   (ovl[ch])
      );
    end else begin : g_ot
      lsd_ovl_ch #(
        .CLS        (CLS_OVERTEMP),
        .OC_DLY_CYC (OC_DLY_CYC)
      ) u_ovl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (int_rst),
        .want_i  (want[ch]),
        .fault_i (ot_i[ch-NUM_OC]),
        .ovl_o   (ovl[ch])
      );
    end
  end

  assign drive_o   = want & ~ovl & {NUM_CH{~int_rst}};
  assign ovl_o     = ovl;
  assign int_rst_o = int_rst;

  p_rst_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_rst_o |-> drive_o == '0);
  p_latched_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_o & ovl_o) == '0);
  p_direct_on_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!direct_ni[0] && !int_rst_o && !ovl_o[0]) |-> drive_o[0]);
  p_quiet_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_i[7] && !ovl_o[7]) |=> !ovl_o[7]);
endmodule

// File: tb/tb_lsd_chan_ctrl.sv
module tb_lsd_chan_ctrl;
  localparam int unsigned DLY = 6;
  localparam int NV = 13;
  // {cmd, direct_n, ext_rst_n, uv, expected drive}
  localparam logic [19:0] VEC [NV] = '{
    {8'h00, 2'b11, 1'b1, 1'b0, 8'h00},
    {8'hFF, 2'b11, 1'b1, 1'b0, 8'hFF},
    {8'h00, 2'b10, 1'b1, 1'b0, 8'h01},
    {8'h00, 2'b01, 1'b1, 1'b0, 8'h02},
    {8'h00, 2'b00, 1'b1, 1'b0, 8'h03},
    {8'h01, 2'b11, 1'b1, 1'b0, 8'h01},
    {8'h03, 2'b00, 1'b1, 1'b0, 8'h03},
    {8'hA5, 2'b11, 1'b1, 1'b0, 8'hA5},
    {8'h5A, 2'b10, 1'b1, 1'b0, 8'h5B},
    {8'hFC, 2'b11, 1'b1, 1'b0, 8'hFC},
    {8'hFF, 2'b00, 1'b0, 1'b0, 8'h00},
    {8'hFF, 2'b00, 1'b1, 1'b1, 8'h00},
    {8'h3C, 2'b11, 1'b1, 1'b0, 8'h3C}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] cmd_i = '0;
  logic [1:0] direct_ni = 2'b11;
  logic [5:0] oc_i = '0;
  logic [1:0] ot_i = '0;
  logic       ext_rst_ni = 1'b1;
  logic       uv_i = 1'b0;
  logic [7:0] drive_o;
  logic [7:0] ovl_o;
  logic       int_rst_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk_i = ~clk_i;

  lsd_chan_ctrl #(.OC_DLY_CYC(DLY)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd_i), .direct_ni(direct_ni),
    .oc_i(oc_i), .ot_i(ot_i), .ext_rst_ni(ext_rst_ni), .uv_i(uv_i),
    .drive_o(drive_o), .ovl_o(ovl_o), .int_rst_o(int_rst_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    chk("reset drive R10", drive_o, 8'h00);
    chk("reset ovl R4", ovl_o, 8'h00);
    chk("reset int_rst R3", {7'd0, int_rst_o}, 8'h00);

    // decode table: R1 R2 R3
    for (int i = 0; i < NV; i++) begin
      {cmd_i, direct_ni, ext_rst_ni, uv_i} = VEC[i][19:8];
      #1;
      chk("table drive R1 R2 R3", drive_o, VEC[i][7:0]);
      chk("table int_rst R3", {7'd0, int_rst_o}, {7'd0, ~VEC[i][9] | VEC[i][8]});
      tick(1);
    end
    ext_rst_ni = 1'b1; uv_i = 1'b0; direct_ni = 2'b11; cmd_i = 8'h00;
    tick(1);

    // R5 trip on exact edge
    cmd_i = 8'h01; oc_i[0] = 1'b1;
    tick(DLY - 1);
    chk("R5 before trip ovl", ovl_o, 8'h00);
    chk("R5 before trip drive", drive_o, 8'h01);
    tick(1);
    chk("R5 at trip ovl", ovl_o, 8'h01);
    chk("R5 at trip drive R10", drive_o, 8'h00);

    // R8 hold then clear
    oc_i[0] = 1'b0;
    tick(3);
    chk("R8 hold", ovl_o, 8'h01);
    cmd_i = 8'h00;
    tick(1);
    chk("R8 clear", ovl_o, 8'h00);
    cmd_i = 8'h01;
    #1;
    chk("R8 re-enable", drive_o, 8'h01);

    // R6 restart on dropout
    oc_i[0] = 1'b1;
    tick(DLY - 1);
    oc_i[0] = 1'b0;
    tick(1);
    oc_i[0] = 1'b1;
    tick(DLY - 1);
    chk("R6 no early trip", ovl_o, 8'h00);
    tick(1);
    chk("R6 trip after full", ovl_o, 8'h01);
    oc_i[0] = 1'b0; cmd_i = 8'h00;
    tick(1);

    // R7 overtemp immediate
    cmd_i = 8'h80; ot_i = 2'b10;
    #1;
    chk("R7 before edge", drive_o, 8'h80);
    tick(1);
    chk("R7 ovl", ovl_o, 8'h80);
    chk("R7 drive", drive_o, 8'h00);
    ot_i = 2'b00; cmd_i = 8'h00;
    tick(1);
    chk("R7 clear R8", ovl_o, 8'h00);

    // R9 faults while off
    oc_i = 6'h3F; ot_i = 2'b11;
    tick(DLY + 2);
    chk("R9 no latch", ovl_o, 8'h00);
    oc_i = '0; ot_i = '0;
    tick(1);

    // R4 internal reset clears latch
    cmd_i = 8'h04; oc_i[2] = 1'b1;
    tick(DLY);
    chk("R4 pre latch", ovl_o, 8'h04);
    uv_i = 1'b1; oc_i[2] = 1'b0;
    #1;
    chk("R3 uv drive off", drive_o, 8'h00);
    tick(1);
    chk("R4 latch cleared", ovl_o, 8'h00);
    uv_i = 1'b0;
    #1;
    chk("R4 follow after release", drive_o, 8'h04);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule